// File: doc/BRIEF.md
# Cascaded-Device SRAM Read Sequencer

This block is the device-side read sequencer for one member of a cascade of up to 31 search devices. All members share a 72-bit bidirectional host bus, a command bus qualified by a valid strobe, and one acknowledge line. The host issues a two-phase Read. Both phases carry the same command and the same address word.

Every member decodes the Read and then runs the same fixed ten-cycle schedule, so that all members stay busy in step. Only the member whose 5-bit identity matches the identity field of the address, and whose address falls in the external SRAM space, actually drives anything:
- the data bus in cycles 4 to 7, after a two-cycle host turnaround;
- a single SRAM read strobe in cycle 7;
- a low-high-low acknowledge pulse in cycles 8 to 10, after which it releases the line.

Tristate is modelled with separate output-enable signals. The cascade is used in its up-to-31-device table configuration (table-size setting binary 10), which is the only configuration this schedule serves.

Cycle numbering is as follows. The clock edge that samples phase A is edge 1, and the edge that samples phase B is edge 2; both phases together form cycle 1. The outputs seen after edge k belong to cycle k.

Top module: `cascade_sram_rd_seq`

## Requirements
- R1: While reset is high and after it, with no command, `dq_oe`, `ack_oe`, `ack_o` and `sram_rd` are all low.
- R2: A Read is accepted only when `cmd_valid` is high with `cmd[1:0]` = 2'b00 on two consecutive edges. A non-Read code, or a phase B without `cmd_valid` high and code 2'b00, starts no sequence, and no enable or strobe rises.
- R3: The member acts only when address bits `dq_i[20:19]` = 2'b10 (SRAM space). Otherwise it keeps `dq_oe`, `ack_oe` and `sram_rd` low for the whole sequence.
- R4: The member acts only when `dq_i[25:21]` equals `dev_id`. Otherwise it keeps all enables and the strobe low.
- R5: For a selected access, `dq_oe` is low in cycles 2 and 3 and high in cycles 4 to 7 inclusive. While it is high, `dq_o` carries the word sampled at phase A.
- R6: For a selected access, `sram_rd` is high for exactly one cycle, cycle 7.
- R7: For a selected access, `ack_oe` is high in cycles 8 to 10, and low before cycle 8 and after cycle 10. `ack_o` is low in cycle 8, high in cycle 9 and low in cycle 10.
- R8: `sram_addr` = {`cmd[8:6]`, `dq_i[20:0]`} sampled at phase A. It appears after edge 1 and holds until the next accepted phase A.
- R9: Commands arriving from edge 3 through edge 11 are ignored, whether the member is selected or not. A new phase A is accepted at edge 12, the first edge after cycle 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per sequence cycle |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 5 | Identity of this cascade member |
| cmd_valid | input | 1 | Command bus valid strobe |
| cmd | input | 11 | Command bus; [1:0] code, [8:6] upper SRAM address |
| dq_i | input | 72 | Host bus as seen at the pins |
| dq_o | output | 72 | Value driven onto the host bus |
| dq_oe | output | 1 | Host bus output enable |
| ack_o | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Acknowledge output enable |
| sram_addr | output | 24 | External SRAM address |
| sram_rd | output | 1 | External SRAM read strobe |

## Verification
Every output is a registered result. The new `sram_addr` is due right after edge 1. The enables and the strobe for cycle k are due right after edge k, counting from the phase A edge, and all of them return to their idle values after edge 11.

The driver drives inputs on falling edges. At each falling edge it pushes the value expected after the next rising edge. The monitor pops that value 2 ns after the rising edge, so every comparison falls in the cycle in which the schedule puts it. Ignored commands are injected during a running sequence, and their absence of effect is read at `sram_addr` and at the unchanged schedule.

// File: rtl/csrs_pkg.sv
package csrs_pkg;

    localparam int DQ_W   = 72;
    localparam int CMD_W  = 11;
    localparam int ID_W   = 5;
    localparam int SADR_W = 24;
    localparam int HI_W   = 3;
    localparam int LOW_W  = SADR_W - HI_W;
    localparam int SEL_LO = 19;
    localparam int ID_LO  = 21;
    localparam int HI_LO  = 6;
    localparam int CYC_W  = 4;

    localparam logic [1:0] RD_CODE    = 2'b00;
    localparam logic [1:0] SRAM_SPACE = 2'b10;

    localparam logic [CYC_W-1:0] CYC_START    = 4'd2;
    localparam logic [CYC_W-1:0] CYC_DQ_FIRST = 4'd4;
    localparam logic [CYC_W-1:0] CYC_DQ_LAST  = 4'd7;
    localparam logic [CYC_W-1:0] CYC_STROBE   = 4'd7;
    localparam logic [CYC_W-1:0] CYC_ACK_LO   = 4'd8;
    localparam logic [CYC_W-1:0] CYC_ACK_HI   = 4'd9;
    localparam logic [CYC_W-1:0] CYC_LAST     = 4'd10;

    typedef struct packed {
        logic              hit;
        logic [SADR_W-1:0] addr;
        logic [DQ_W-1:0]   word;
    } req_t;

    typedef struct packed {
        logic dq_oe;
        logic rd;
        logic ack_oe;
        logic ack;
    } drive_t;

    function automatic logic is_read(input logic valid, input logic [1:0] code);
        return valid && (code == RD_CODE);
    endfunction

    function automatic logic targets_me(input logic [DQ_W-1:0] dq, input logic [ID_W-1:0] id);
        return (dq[SEL_LO +: 2] == SRAM_SPACE) && (dq[ID_LO +: ID_W] == id);
    endfunction

    function automatic drive_t sched_drive(input logic [CYC_W-1:0] cyc);
        drive_t d;
        d.dq_oe  = (cyc >= CYC_DQ_FIRST) && (cyc <= CYC_DQ_LAST);
        d.rd     = (cyc == CYC_STROBE);
        d.ack_oe = (cyc >= CYC_ACK_LO) && (cyc <= CYC_LAST);
        d.ack    = (cyc == CYC_ACK_HI);
        return d;
    endfunction

endpackage

// File: rtl/csrs_decode.sv
module csrs_decode
    import csrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [ID_W-1:0]  dev_id,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd,
    input  logic [DQ_W-1:0]  dq_i,
    output logic             start,
    output req_t             req
);

    logic in_phase_b;
    logic unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd[CMD_W-1:HI_LO+HI_W], cmd[HI_LO-1:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            in_phase_b <= 1'b0;
            req        <= '0;
        end else if (in_phase_b) begin
            in_phase_b <= 1'b0;
        end else if (!busy && is_read(cmd_valid, cmd[1:0])) begin
            in_phase_b <= 1'b1;
            req.hit    <= targets_me(dq_i, dev_id);
            req.addr   <= {cmd[HI_LO +: HI_W], dq_i[LOW_W-1:0]};
            req.word   <= dq_i;
        end
    end

    assign start = in_phase_b && is_read(cmd_valid, cmd[1:0]);

endmodule

// File: rtl/csrs_sched.sv
module csrs_sched
    import csrs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   hit,
    output logic   busy,
    output drive_t drv
);

    logic             running;
    logic             selected;
    logic [CYC_W-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            selected <= 1'b0;
            cyc      <= '0;
        end else if (running) begin
            if (cyc == CYC_LAST) begin
                running  <= 1'b0;
                selected <= 1'b0;
                cyc      <= '0;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end else if (start) begin
            running  <= 1'b1;
            selected <= hit;
            cyc      <= CYC_START;
        end
    end

    assign busy = running;

    always_comb begin
        if (running && selected) drv = sched_drive(cyc);
        else                     drv = '0;
    end

endmodule

// File: rtl/cascade_sram_rd_seq.sv
module cascade_sram_rd_seq
    import csrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DQ_W-1:0]   dq_i,
    output logic [DQ_W-1:0]   dq_o,
    output logic              dq_oe,
    output logic              ack_o,
    output logic              ack_oe,
    output logic [SADR_W-1:0] sram_addr,
    output logic              sram_rd
);

    logic   busy;
    logic   start;
    req_t   req;
    drive_t drv;

    csrs_decode i_decode (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .dev_id    (dev_id),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .dq_i      (dq_i),
        .start     (start),
        .req       (req)
    );

    csrs_sched i_sched (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .hit   (req.hit),
        .busy  (busy),
        .drv   (drv)
    );

    assign dq_o      = req.word;
    assign sram_addr = req.addr;
    assign dq_oe     = drv.dq_oe;
    assign sram_rd   = drv.rd;
    assign ack_oe    = drv.ack_oe;
    assign ack_o     = drv.ack;

endmodule

// File: rtl/csrs_checker.sv
module csrs_checker
    import csrs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ID_W-1:0]   dev_id,
    input logic [DQ_W-1:0]   dq_o,
    input logic              dq_oe,
    input logic              ack_o,
    input logic              ack_oe,
    input logic [SADR_W-1:0] sram_addr,
    input logic              sram_rd
);

    assert_space_match_R3: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (dq_o[SEL_LO +: 2] == SRAM_SPACE));

    assert_id_match_R4: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (dq_o[ID_LO +: ID_W] == dev_id));

    assert_drive_span_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |=> (dq_oe && !sram_rd));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        sram_rd |=> !sram_rd);

    assert_strobe_in_drive_R6: assert property (@(posedge clk) disable iff (rst)
        sram_rd |-> dq_oe);

    assert_ack_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        sram_rd |=> (ack_oe && !ack_o && !dq_oe));

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && ack_o) |=> (ack_oe && !ack_o));

    assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && !ack_o && $past(ack_o)) |=> !ack_oe);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dq_oe || ack_oe) |-> $stable(sram_addr));

endmodule

bind cascade_sram_rd_seq csrs_checker i_chk (.*);

// File: tb/test_cascade_sram_rd_seq.sv
module test_cascade_sram_rd_seq;

    typedef struct {
        bit          dq_oe;
        bit          rd;
        bit          ack_oe;
        bit          ack;
        logic [71:0] word;
        logic [23:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  dev_id = 5'd0;
    logic        cmd_valid = 1'b0;
    logic [10:0] cmd = '0;
    logic [71:0] dq_i = '0;
    logic [71:0] dq_o;
    logic        dq_oe, ack_o, ack_oe, sram_rd;
    logic [23:0] sram_addr;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t q[$];
    logic [23:0] exp_addr = '0;
    logic [71:0] exp_word = '0;

    always #5 clk = ~clk;

    cascade_sram_rd_seq i_cascade_sram_rd_seq (
        .clk(clk), .rst(rst), .dev_id(dev_id), .cmd_valid(cmd_valid), .cmd(cmd),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .ack_o(ack_o), .ack_oe(ack_oe),
        .sram_addr(sram_addr), .sram_rd(sram_rd)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int k, input bit hit, input string tag);
        exp_t e;
        e.dq_oe  = hit && (k >= 4) && (k <= 7);
        e.rd     = hit && (k == 7);
        e.ack_oe = hit && (k >= 8) && (k <= 10);
        e.ack    = hit && (k == 9);
        e.word   = exp_word;
        e.addr   = exp_addr;
        e.tag    = tag;
        q.push_back(e);
    endtask

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(dq_oe == e.dq_oe, e.tag, "dq_oe (R5)", 72'(dq_oe), 72'(e.dq_oe));
                check(sram_rd == e.rd, e.tag, "sram_rd (R6)", 72'(sram_rd), 72'(e.rd));
                check(ack_oe == e.ack_oe, e.tag, "ack_oe (R7)", 72'(ack_oe), 72'(e.ack_oe));
                if (e.ack_oe)
                    check(ack_o == e.ack, e.tag, "ack_o (R7)", 72'(ack_o), 72'(e.ack));
                if (e.dq_oe)
                    check(dq_o == e.word, e.tag, "dq_o (R5)", dq_o, e.word);
                check(sram_addr == e.addr, e.tag, "sram_addr (R8)", 72'(sram_addr), 72'(e.addr));
            end
        end
    end

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cmd       = '0;
            push(0, 1'b0, tag);
        end
    endtask

    // one Read: phase A, phase B, then cycles 3..11
    task automatic run_read(input logic [4:0] id_f, input logic [1:0] sp,
                            input logic [2:0] hi, input logic [18:0] low,
                            input logic [45:0] fill, input bit b_ok,
                            input bit noise, input string tag);
        bit hit;
        hit = (sp == 2'b10) && (id_f == dev_id) && b_ok;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd       = {2'b00, hi, 4'b0000, 2'b00};
        dq_i      = {fill, id_f, sp, low};
        exp_addr  = {hi, sp, low};
        exp_word  = dq_i;
        push(1, 1'b0, tag);
        @(negedge clk);
        cmd_valid = b_ok;
        push(2, 1'b0, tag);
        if (!b_ok) return;
        for (int k = 3; k <= 11; k++) begin
            @(negedge clk);
            if (noise) begin
                cmd_valid = 1'b1;
                cmd       = {2'b00, ~hi, 4'b0000, 2'b00};
                dq_i      = {~fill, dev_id, 2'b10, ~low};
            end else begin
                cmd_valid = 1'b0;
                dq_i      = '0;
            end
            push(k, hit, tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!dq_oe && !ack_oe && !sram_rd, "R1", "enables in reset",
              72'({dq_oe, ack_oe, sram_rd}), 72'(0));
        @(negedge clk);
        rst = 1'b0;
        idle(3, "R1");

        // selected member, SRAM space
        run_read(5'd0, 2'b10, 3'b101, 19'h1_2345, 46'h0abc_dead_beef, 1'b1, 1'b0, "R5_R6_R7_R8 hit");
        idle(2, "R1 idle after");

        // commands during the sequence must be ignored
        run_read(5'd0, 2'b10, 3'b011, 19'h7_0f0f, 46'h1111_2222_3333, 1'b1, 1'b1, "R9 noise");
        idle(1, "R9 after noise");

        // back-to-back: new phase A at edge 12
        run_read(5'd0, 2'b10, 3'b001, 19'h0_0001, 46'h3fff_ffff_ffff, 1'b1, 1'b0, "R9 b2b first");
        run_read(5'd0, 2'b10, 3'b110, 19'h5_5555, 46'h0000_0000_0001, 1'b1, 1'b0, "R9 b2b second");

        // wrong address space
        run_read(5'd0, 2'b01, 3'b111, 19'h2_aaaa, 46'h0123_4567_89ab, 1'b1, 1'b0, "R3 space 01");
        run_read(5'd0, 2'b11, 3'b000, 19'h3_3333, 46'h0, 1'b1, 1'b0, "R3 space 11");

        // wrong identity (member stays busy but silent)
        run_read(5'd9, 2'b10, 3'b010, 19'h4_4444, 46'h2222_0000_1111, 1'b1, 1'b1, "R4 other id");
        idle(1, "R4 after");

        // phase B missing, then phase B with the wrong code
        run_read(5'd0, 2'b10, 3'b100, 19'h6_6666, 46'h1, 1'b0, 1'b0, "R2 no phase B");
        idle(12, "R2 abort idle");
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd       = {2'b00, 3'b111, 4'b0000, 2'b01};
        dq_i      = {46'h5, 5'd0, 2'b10, 19'h0_0777};
        push(0, 1'b0, "R2 non-read code");
        @(negedge clk);
        push(0, 1'b0, "R2 non-read code");
        idle(12, "R2 non-read idle");

        // another identity value
        @(negedge clk);
        dev_id = 5'd30;
        push(0, 1'b0, "R4 id change");
        run_read(5'd30, 2'b10, 3'b011, 19'h7_ffff, 46'h3abc_0000_0042, 1'b1, 1'b0, "R4 id 30");
        run_read(5'd0, 2'b10, 3'b011, 19'h1_0000, 46'h7, 1'b1, 1'b0, "R4 id 0 vs 30");
        idle(2, "R1 final idle");

        wait (q.size() == 0);
        @(posedge clk);
        #4;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule